// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the digital front end of a 2048-byte serial EEPROM. It watches a two-wire bus whose clock and data lines are already synchronised to the system clock. It recognises bus START and STOP events and answers to the device code 1010. It then runs byte writes, page writes of up to 16 bytes, current-address reads, random reads and sequential reads against an internal synchronous RAM that stands in for the nonvolatile array.

Written bytes first gather in a page buffer. The STOP that closes the transfer hands them to a write-cycle controller. That controller stays busy for a fixed number of clocks, commits the buffered bytes and, while it runs, makes the slave refuse its own address. A master can therefore poll for completion. A write-protect input blocks every commit. The slave drives the data line through an open-drain enable and never drives it high.

Top module: `eep_slave_top`

## Requirements
- R1: After reset, `sda_oe` is low and no write cycle is running, so a control byte sent straight after reset is acknowledged.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either event, arriving in any state, discards a partly received byte. After a START the next 8 bits are taken as a control byte. A STOP in the middle of a data byte starts no write cycle.
- R3: A control byte whose top four bits (bits 7..4) are not 1010 gets no acknowledge. Every later byte is then ignored until the next START.
- R4: After a STOP that ends a write with at least one accepted data byte, the engine is busy for WR_CYCLES clocks. While busy, a matching control byte gets no acknowledge (SDA stays released on the ninth clock). Once the cycle is over, the same byte is acknowledged.
- R5: Control-byte bits 3..1 become address bits 10..8, and bit 0 selects read (1) or write (0). In a write, the byte after the control byte is acknowledged and becomes address bits 7..0.
- R6: Each data byte of a write is acknowledged and buffered at the pointer. The pointer's low 4 bits then advance and wrap inside the 16-byte page, so a seventeenth byte overwrites the first. Buffered bytes reach memory only after the STOP.
- R7: With `wp_i` high, the control byte and the address byte are acknowledged. The first data byte is not acknowledged, no write cycle follows the STOP, and memory keeps its old contents.
- R8: A repeated START after the address byte of a write keeps the loaded pointer, so a following read returns the byte at that address.
- R9: A read that follows no address byte returns the byte one past the last one accessed. Its bits 10..8 come from the new control byte.
- R10: In a read, a master acknowledge on the ninth clock makes the slave send the next byte. The 11-bit pointer wraps from 0x7FF to 0x000.
- R11: A master no-acknowledge on the ninth clock of a read makes the slave release SDA and stay silent until the STOP.
- R12: Bytes travel MSB first. The slave samples SDA on rising SCL and changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock, synchronised |
| sda_i | input | 1 | Bus data line level, synchronised |
| wp_i | input | 1 | Write protect, high blocks all commits |
| sda_oe | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
The bench builds the block with WR_CYCLES = 400 and keeps the default 16-byte page. A short write cycle brings the busy window within reach of a poll issued right after the STOP, and also lets the bench see the same poll acknowledged after the cycle, without millions of idle clocks. A 16-byte page is short enough that an 18-byte burst exercises the in-page wrap. Each SCL half period lasts 8 system clocks, so every bus edge is resolved by the edge detector.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BLK_W  = 3;
  localparam int WORD_W = 8;
  localparam int ADDR_W = BLK_W + WORD_W;
endpackage

// File: rtl/eep_busmon.sv
module eep_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
  assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_i,
  input  logic              busy,
  input  logic              wp_i,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sda_oe,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [7:0]        wb_data,
  output logic              wb_clr,
  output logic              commit_go,
  output logic              in_ctrl
);
  phase_t            ph;
  logic [3:0]        cnt;
  logic              in_ack, rw, mack;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] ptr;

  assign rd_addr = ptr;
  assign in_ctrl = (ph == PH_CTRL);

  always_ff @(posedge clk) begin
    wb_we     <= 1'b0;
    wb_clr    <= 1'b0;
    commit_go <= 1'b0;
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      ptr <= '0; sh <= '0; tx <= '0; rw <= 1'b0; mack <= 1'b0;
      wb_addr <= '0; wb_data <= '0;
    end else if (bus_start) begin
      ph <= PH_CTRL; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (bus_stop) begin
      ph <= PH_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      commit_go <= 1'b1;
    end else if (ph != PH_IDLE) begin
      if (scl_rise && !in_ack && cnt < 4'd8) begin
        cnt <= cnt + 4'd1;
        if (ph != PH_RDATA) sh <= {sh[6:0], sda_i};
      end
      if (scl_rise && in_ack && ph == PH_RDATA) mack <= ~sda_i;
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (ph)
            PH_CTRL: begin
              if (rw) begin
                ph <= PH_RDATA;
                tx <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end else begin
                ph <= PH_ADDR;
              end
            end
            PH_ADDR: ph <= PH_WDATA;
            PH_RDATA: begin
              if (mack) begin
                tx <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end else begin
                ph <= PH_IDLE;
              end
            end
            default: ;
          endcase
        end else if (cnt == 4'd8) begin
          case (ph)
            PH_CTRL: begin
              if (sh[7:4] == DEV_CODE && !busy) begin
                sda_oe <= 1'b1; in_ack <= 1'b1; rw <= sh[0];
                ptr[ADDR_W-1 -: BLK_W] <= sh[3:1];
                wb_clr <= ~sh[0];
              end else begin
                ph <= PH_IDLE;
              end
            end
            PH_ADDR: begin
              sda_oe <= 1'b1; in_ack <= 1'b1;
              ptr[WORD_W-1:0] <= sh;
            end
            PH_WDATA: begin
              if (wp_i) begin
                ph <= PH_IDLE; wb_clr <= 1'b1;
              end else begin
                sda_oe <= 1'b1; in_ack <= 1'b1;
                wb_we <= 1'b1; wb_addr <= ptr; wb_data <= sh;
                ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
              end
            end
            PH_RDATA: begin
              sda_oe <= 1'b0; in_ack <= 1'b1; mack <= 1'b0;
            end
            default: ;
          endcase
        end else if (ph == PH_RDATA && cnt != 4'd0) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end
endmodule

// File: rtl/eep_commit.sv
module eep_commit
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_we,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [7:0]        wb_data,
  input  logic              wb_clr,
  input  logic              commit_go,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wd
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [7:0]           pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [ADDR_W-PW-1:0] base;
  logic [CW-1:0]        tick;

  always_ff @(posedge clk) begin
    if (wb_we) pbuf[wb_addr[PW-1:0]] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0; busy <= 1'b0; tick <= '0; base <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wd <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        tick <= tick + 1'b1;
        if (tick < CW'(PAGE_BYTES) && mask[tick[PW-1:0]]) begin
          mem_we   <= 1'b1;
          mem_addr <= {base, tick[PW-1:0]};
          mem_wd   <= pbuf[tick[PW-1:0]];
        end
        if (tick == CW'(WR_CYCLES - 1)) begin
          busy <= 1'b0;
          mask <= '0;
        end
      end else if (commit_go && |mask) begin
        busy <= 1'b1;
        tick <= '0;
      end
      if (wb_clr) mask <= '0;
      if (wb_we) begin
        mask[wb_addr[PW-1:0]] <= 1'b1;
        base <= wb_addr[ADDR_W-1:PW];
      end
    end
  end
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    q <= mem[raddr];
  end
endmodule

// File: rtl/eep_slave_top.sv
module eep_slave_top
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic              scl_rise, scl_fall, bus_start, bus_stop;
  logic              busy, wb_we, wb_clr, commit_go, in_ctrl, mem_we;
  logic [ADDR_W-1:0] rd_addr, wb_addr, mem_addr;
  logic [7:0]        rd_data, wb_data, mem_wd;

  eep_busmon u_busmon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  eep_proto #(.PW(PW)) u_proto (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_i(sda_i),
    .busy(busy), .wp_i(wp_i), .rd_data(rd_data), .rd_addr(rd_addr),
    .sda_oe(sda_oe), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_clr(wb_clr), .commit_go(commit_go), .in_ctrl(in_ctrl)
  );

  eep_commit #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .wb_we(wb_we), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_clr(wb_clr), .commit_go(commit_go),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wd(mem_wd)
  );

  eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wd(mem_wd),
    .raddr(rd_addr), .q(rd_data)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic busy,
  input logic mem_we,
  input logic in_ctrl
);
  p_reset_release_r1: assert property (@(posedge clk)
    rst |=> (!sda_oe && !busy));

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  p_busy_mute_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && in_ctrl) |-> !sda_oe);

  p_we_in_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

bind eep_slave_top eep_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .busy(busy), .mem_we(mem_we), .in_ctrl(in_ctrl)
);

// File: tb/eep_slave_top_bench.sv
module eep_slave_top_bench;
  localparam int WRC = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:31];

  always #2.5 clk = ~clk;

  eep_slave_top #(.PAGE_BYTES(16), .WR_CYCLES(WRC)) u_eep_slave_top (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .sda_oe(sda_oe)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wt(4);
    scl = 1'b1; wt(4);
    r = sda_line; wt(4);
    scl = 1'b0; wt(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4);
    scl = 1'b1; wt(6);
    sda_m = 1'b0; wt(6);
    scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4);
    scl = 1'b1; wt(6);
    sda_m = 1'b1; wt(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(~m_ack, r);
  endtask

  function automatic logic [7:0] ctl(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  // write n bytes from wbuf starting at address a, then STOP
  task automatic do_write(input logic [10:0] a, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(ctl(a, 1'b0), ack); check({req, " ctrl ack"}, ack, 1);
    send_byte(a[7:0], ack);       check({req, " addr ack R5"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (i == 0 || i == n - 1) check({req, " data ack R6"}, ack, 1);
    end
    bus_stop();
  endtask

  // set pointer, repeated START, read n bytes into rbuf
  task automatic do_rand_read(input logic [10:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(ctl(a, 1'b0), ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(ctl(a, 1'b1), ack);
    check("R8 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      rbuf[i] = d;
    end
  endtask

  task automatic poll(output logic ack);
    bus_start();
    send_byte(ctl(11'h123, 1'b0), ack);
    bus_stop();
  endtask

  task automatic t_reset();
    logic ack;
    check("R1 sda_oe after reset", sda_oe, 0);
    poll(ack);
    check("R1 no cycle after reset", ack, 1);
  endtask

  task automatic t_write_poll();
    logic ack;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    do_write(11'h123, 2, "R5/R6 byte write");
    poll(ack);
    check("R4 busy poll nack", ack, 0);
    wt(WRC);
    poll(ack);
    check("R4 poll ack after cycle", ack, 1);
  endtask

  task automatic t_random_current();
    logic ack;
    logic [7:0] d;
    do_rand_read(11'h123, 1);
    check("R8/R12 random read 0x123", rbuf[0], 8'hA5);
    check("R11 sda released after nack", sda_oe, 0);
    check("R11 line high after nack", sda_line, 1);
    bus_stop();
    bus_start();
    send_byte(ctl(11'h100, 1'b1), ack);
    check("R9 current read ctrl ack", ack, 1);
    recv_byte(1'b0, d);
    bus_stop();
    check("R9 current read 0x124", d, 8'h5A);
  endtask

  task automatic t_page_wrap();
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
    do_write(11'h2F0, 18, "R6 page burst");
    wt(WRC + 20);
    do_rand_read(11'h2F0, 16);
    bus_stop();
    check("R6 rollover byte 0", rbuf[0], 8'h50);
    check("R6 rollover byte 1", rbuf[1], 8'h51);
    for (int i = 2; i < 16; i++)
      check("R10 sequential page byte", rbuf[i], 8'h40 + i);
  endtask

  task automatic t_addr_wrap();
    wbuf[0] = 8'hC3;
    do_write(11'h7FF, 1, "R10 top byte");
    wt(WRC + 20);
    wbuf[0] = 8'h3C;
    do_write(11'h000, 1, "R10 bottom byte");
    wt(WRC + 20);
    do_rand_read(11'h7FF, 2);
    bus_stop();
    check("R10 read 0x7FF", rbuf[0], 8'hC3);
    check("R10 wrap to 0x000", rbuf[1], 8'h3C);
  endtask

  task automatic t_protect();
    logic ack;
    wp = 1'b1;
    bus_start();
    send_byte(ctl(11'h123, 1'b0), ack); check("R7 ctrl ack under wp", ack, 1);
    send_byte(8'h23, ack);              check("R7 addr ack under wp", ack, 1);
    send_byte(8'h00, ack);              check("R7 data nack under wp", ack, 0);
    bus_stop();
    poll(ack);
    check("R7 no write cycle", ack, 1);
    wp = 1'b0;
    do_rand_read(11'h123, 1);
    bus_stop();
    check("R7 memory unchanged", rbuf[0], 8'hA5);
  endtask

  task automatic t_bad_code();
    logic ack;
    bus_start();
    send_byte(8'h50, ack);
    check("R3 wrong code nack", ack, 0);
    send_byte(8'hA0, ack);
    check("R3 ignored until START", ack, 0);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ack;
    logic r;
    bus_start();
    for (int i = 0; i < 4; i++) bit_io(1'b1, r);
    do_rand_read(11'h123, 1);
    bus_stop();
    check("R2 restart drops partial ctrl", rbuf[0], 8'hA5);
    bus_start();
    send_byte(ctl(11'h123, 1'b0), ack);
    send_byte(8'h23, ack);
    for (int i = 0; i < 3; i++) bit_io(1'b0, r);
    bus_stop();
    poll(ack);
    check("R2 stop mid-byte starts no cycle", ack, 1);
    do_rand_read(11'h123, 1);
    bus_stop();
    check("R2 partial byte not stored", rbuf[0], 8'hA5);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_write_poll();
    t_random_current();
    t_page_wrap();
    t_addr_wrap();
    t_protect();
    t_bad_code();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule